// File: doc/BRIEF.md
# Subroutine Call Frame Sequencer

This block carries out a register-indirect subroutine call for a small processor. In that processor, register 0 holds the frame pointer and register 1 holds the stack pointer. When the decode stage presents the call instruction together with the target register value, the PC, the frame pointer and the stack pointer, the sequencer takes a copy of these operands. It then pushes two 32-bit words onto a stack that grows downward. The first word is the return address and the second is the old frame pointer. Each push goes through a simple request/acknowledge write port.

After the second push is acknowledged, the sequencer commits its results in a single cycle. Both pointer registers take the new stack top, the PC takes the call target, and a one-cycle done pulse marks the end of the sequence. The register file and the memory are outside the block and are reached through its ports. The block drives a combinational read select so that the register file can supply the target register value.

Top module: `call_frame_seq`

## Requirements
- R1: A start request is accepted only when the sequencer is idle and instruction bits 15:9 equal 0x18. Any other start has no effect: busy, the write request and done all stay low.
- R2: The target register read select `tgt_sel_o` always equals instruction bits 8:6.
- R3: The first store writes the return address, PC + 2, to the address SP − 4.
- R4: The second store writes the captured frame pointer to the address SP − 8.
- R5: A write request stays asserted, with stable address and data, until it is acknowledged. The second store is issued only after the first store's acknowledge.
- R6: In the cycle after the second acknowledge, `reg_we_o`, `pc_we_o` and `done_o` are high for exactly one cycle. In that cycle `reg_wdata_o` is SP − 8 (the value for both register 0 and register 1) and `pc_wdata_o` is the target register value.
- R7: `busy_o` is high from the cycle after acceptance through the commit cycle. A start request while busy is ignored.
- R8: Operands are captured at acceptance, so later changes on the operand inputs do not affect the stores or the commit.
- R9: While reset is asserted and after it is released, the sequencer is idle. No write is pending and busy and done are low.
- R10: Address and return-address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to execute the presented instruction |
| instr_i | input | 16 | Instruction word |
| tgt_sel_o | output | 3 | Register file read select for the call target |
| tgt_val_i | input | 32 | Value of the selected target register |
| pc_i | input | 32 | PC of the call instruction |
| fp_i | input | 32 | Current register 0 (frame pointer) |
| sp_i | input | 32 | Current register 1 (stack pointer) |
| wr_req_o | output | 1 | Memory word write request |
| wr_addr_o | output | 32 | Byte address of the word write |
| wr_data_o | output | 32 | Word to store |
| wr_ack_i | input | 1 | Write acknowledge |
| reg_we_o | output | 1 | Write enable for registers 0 and 1 |
| reg_wdata_o | output | 32 | New value for registers 0 and 1 |
| pc_we_o | output | 1 | PC write enable |
| pc_wdata_o | output | 32 | New PC value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check four properties of the write port and the commit. A write request is held with stable address and data until acknowledged. No request is made while idle. Done lasts one cycle, coincides with both write enables and follows an acknowledge. The committed pointer value equals the address of the second store. Only the directed scenarios can show the absolute values. These are the two store addresses and data, the target PC, the opcode filter, the rejection of a start while busy, operand capture against changing inputs, and wraparound near address zero.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PUSH_RA = 2'd1,
    ST_PUSH_FP = 2'd2,
    ST_COMMIT  = 2'd3
  } cfs_state_e;
endpackage

// File: rtl/cfs_ctrl.sv
module cfs_ctrl
  import cfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       ack_i,
  output cfs_state_e state_o,
  output logic       capture_o,
  output logic       busy_o,
  output logic       req_o,
  output logic       commit_o
);
  cfs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (go_i)  state_d = ST_PUSH_RA;
      ST_PUSH_RA: if (ack_i) state_d = ST_PUSH_FP;
      ST_PUSH_FP: if (ack_i) state_d = ST_COMMIT;
      ST_COMMIT:             state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && go_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign req_o     = (state_q == ST_PUSH_RA) || (state_q == ST_PUSH_FP);
  assign commit_o  = (state_q == ST_COMMIT);
endmodule

// File: rtl/cfs_hold_reg.sv
module cfs_hold_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb q_d = en_i ? d_i : q_q;

  always_ff @(posedge clk) q_q <= q_d;

  assign q_o = q_q;
endmodule

// File: rtl/cfs_addr_calc.sv
module cfs_addr_calc #(
  parameter int XLEN       = 32,
  parameter int WORD_BYTES = 4,
  parameter int INSN_BYTES = 2
) (
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] ra_slot_o,
  output logic [XLEN-1:0] fp_slot_o,
  output logic [XLEN-1:0] ret_addr_o
);
  localparam logic [XLEN-1:0] STEP1 = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * WORD_BYTES);
  localparam logic [XLEN-1:0] ILEN  = XLEN'(INSN_BYTES);

  assign ra_slot_o  = sp_i - STEP1;
  assign fp_slot_o  = sp_i - STEP2;
  assign ret_addr_o = pc_i + ILEN;
endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
  import cfs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSTR_W    = 16,
  parameter int OPC_LSB    = 9,
  parameter int SEL_LSB    = 6,
  parameter int SEL_W      = 3,
  parameter int CALL_OPC   = 8'h18,
  parameter int WORD_BYTES = 4,
  parameter int INSN_BYTES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [SEL_W-1:0]   tgt_sel_o,
  input  logic [XLEN-1:0]    tgt_val_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    fp_i,
  input  logic [XLEN-1:0]    sp_i,
  output logic               wr_req_o,
  output logic [XLEN-1:0]    wr_addr_o,
  output logic [XLEN-1:0]    wr_data_o,
  input  logic               wr_ack_i,
  output logic               reg_we_o,
  output logic [XLEN-1:0]    reg_wdata_o,
  output logic               pc_we_o,
  output logic [XLEN-1:0]    pc_wdata_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int OPC_W = INSTR_W - OPC_LSB;
  localparam int NOPS  = 4;

  cfs_state_e state;
  logic       is_call, go, capture, req, commit;
  logic [OPC_W-1:0] opc;

  assign opc       = instr_i[INSTR_W-1:OPC_LSB];
  assign is_call   = (opc == OPC_W'(CALL_OPC));
  assign go        = start_i && is_call;
  assign tgt_sel_o = instr_i[SEL_LSB +: SEL_W];

  cfs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go),
    .ack_i     (wr_ack_i),
    .state_o   (state),
    .capture_o (capture),
    .busy_o    (busy_o),
    .req_o     (req),
    .commit_o  (commit)
  );

  // Operand capture: 0 target, 1 pc, 2 fp, 3 sp
  logic [XLEN-1:0] op_in [NOPS];
  logic [XLEN-1:0] op_q  [NOPS];
  assign op_in[0] = tgt_val_i;
  assign op_in[1] = pc_i;
  assign op_in[2] = fp_i;
  assign op_in[3] = sp_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_hold
    cfs_hold_reg #(.W(XLEN)) u_hold (
      .clk  (clk),
      .en_i (capture),
      .d_i  (op_in[g]),
      .q_o  (op_q[g])
    );
  end

  logic [XLEN-1:0] ra_slot, fp_slot, ret_addr;

  cfs_addr_calc #(
    .XLEN       (XLEN),
    .WORD_BYTES (WORD_BYTES),
    .INSN_BYTES (INSN_BYTES)
  ) u_calc (
    .sp_i       (op_q[3]),
    .pc_i       (op_q[1]),
    .ra_slot_o  (ra_slot),
    .fp_slot_o  (fp_slot),
    .ret_addr_o (ret_addr)
  );

  always_comb begin
    if (state == ST_PUSH_FP) begin
      wr_addr_o = fp_slot;
      wr_data_o = op_q[2];
    end else begin
      wr_addr_o = ra_slot;
      wr_data_o = ret_addr;
    end
  end

  assign wr_req_o    = req;
  assign reg_we_o    = commit;
  assign pc_we_o     = commit;
  assign done_o      = commit;
  assign reg_wdata_o = fp_slot;
  assign pc_wdata_o  = op_q[0];
endmodule

// File: rtl/call_frame_seq_chk.sv
module call_frame_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_req_o,
  input logic            wr_ack_i,
  input logic [XLEN-1:0] wr_addr_o,
  input logic [XLEN-1:0] wr_data_o,
  input logic            reg_we_o,
  input logic            pc_we_o,
  input logic            done_o,
  input logic            busy_o,
  input logic [XLEN-1:0] reg_wdata_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R5
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_req_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_COMMIT_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> reg_we_o && pc_we_o && busy_o && !wr_req_o); // R6
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_req_o && wr_ack_i)); // R6
  AST_FRAME_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> reg_wdata_o == $past(wr_addr_o)); // R4
endmodule

bind call_frame_seq call_frame_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_req_o    (wr_req_o),
  .wr_ack_i    (wr_ack_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .reg_we_o    (reg_we_o),
  .pc_we_o     (pc_we_o),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .reg_wdata_o (reg_wdata_o)
);

// File: tb/call_frame_seq_tb_top.sv
module call_frame_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] instr_i;
  logic [2:0]  tgt_sel_o;
  logic [31:0] tgt_val_i, pc_i, fp_i, sp_i;
  logic        wr_req_o;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        wr_ack_i;
  logic        reg_we_o, pc_we_o, busy_o, done_o;
  logic [31:0] reg_wdata_o, pc_wdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  call_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
    .tgt_sel_o(tgt_sel_o), .tgt_val_i(tgt_val_i), .pc_i(pc_i), .fp_i(fp_i),
    .sp_i(sp_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .reg_we_o(reg_we_o),
    .reg_wdata_o(reg_wdata_o), .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [15:0] mk_instr(input logic [6:0] opc, input logic [2:0] sel);
    return {opc, sel, 6'b000101};
  endfunction

  // Scenario: reset state (R9)
  task automatic t_reset();
    rst_n = 1'b0; start_i = 0; wr_ack_i = 0; instr_i = '0;
    tgt_val_i = '0; pc_i = '0; fp_i = '0; sp_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !wr_req_o && !done_o, "R9 in reset", {busy_o, wr_req_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !wr_req_o && !done_o, "R9 after release", {busy_o, wr_req_o, done_o}, 0);
  endtask

  // Scenario: one full call with checks on stores, order, stability and commit
  task automatic t_call(input string name, input logic [2:0] sel, input logic [31:0] tgt,
                        input logic [31:0] pc, input logic [31:0] fp, input logic [31:0] sp,
                        input int delay, input bit poke);
    logic [31:0] ea [2];
    logic [31:0] ed [2];
    logic [31:0] hold_a, hold_d;
    int nw = 0;
    int waits = 0;
    bit got_done = 0;
    ea[0] = sp - 32'd4; ed[0] = pc + 32'd2;
    ea[1] = sp - 32'd8; ed[1] = fp;
    @(negedge clk);
    instr_i = mk_instr(7'h18, sel);
    tgt_val_i = tgt; pc_i = pc; fp_i = fp; sp_i = sp;
    #1;
    chk(tgt_sel_o == sel, {"R2 select ", name}, 32'(tgt_sel_o), 32'(sel));
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    // R8: scramble operand inputs after acceptance
    tgt_val_i = ~tgt; pc_i = ~pc; fp_i = ~fp; sp_i = ~sp;
    chk(busy_o, {"R7 busy after accept ", name}, 32'(busy_o), 1);
    hold_a = wr_addr_o; hold_d = wr_data_o;
    for (int cyc = 0; cyc < 60; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (poke && cyc == 1) begin
        instr_i = mk_instr(7'h18, 3'd7); start_i = 1;
      end else begin
        start_i = 0;
      end
      if (wr_ack_i) begin
        wr_ack_i = 0; waits = 0;
        if (wr_req_o) begin hold_a = wr_addr_o; hold_d = wr_data_o; end
      end
      if (done_o) begin
        got_done = 1;
        chk(nw == 2, {"R6 done after two stores ", name}, nw, 2);
        chk(reg_we_o && pc_we_o, {"R6 write enables ", name}, {reg_we_o, pc_we_o}, 2'b11);
        chk(reg_wdata_o == sp - 32'd8, {"R6 new frame ", name}, reg_wdata_o, sp - 32'd8);
        chk(pc_wdata_o == tgt, {"R6 new pc ", name}, pc_wdata_o, tgt);
        break;
      end
      if (wr_req_o) begin
        if (waits > 0)
          chk(wr_addr_o == hold_a && wr_data_o == hold_d, {"R5 stable ", name},
              wr_addr_o, hold_a);
        if (waits == delay) begin
          if (nw < 2) begin
            chk(wr_addr_o == ea[nw], {(nw == 0) ? "R3 addr " : "R4 addr ", name},
                wr_addr_o, ea[nw]);
            chk(wr_data_o == ed[nw], {(nw == 0) ? "R3 data " : "R4 data ", name},
                wr_data_o, ed[nw]);
          end
          nw++;
          wr_ack_i = 1;
        end else begin
          waits++;
        end
      end
    end
    start_i = 0;
    chk(got_done, {"R6 done seen ", name}, 32'(got_done), 1);
    @(negedge clk);
    chk(!busy_o && !done_o && !wr_req_o, {"R7 idle after commit ", name},
        {busy_o, done_o, wr_req_o}, 0);
  endtask

  // Scenario: start with a non-call opcode is ignored (R1)
  task automatic t_not_call(input logic [6:0] opc);
    @(negedge clk);
    instr_i = mk_instr(opc, 3'd2); sp_i = 32'h100; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < 3; i++) begin
      chk(!busy_o && !wr_req_o && !done_o, "R1 non-call ignored",
          {busy_o, wr_req_o, done_o}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_call("basic",   3'd3, 32'h0000_4000, 32'h0000_1000, 32'h0000_8000, 32'h0000_9000, 0, 0);
    t_call("waits",   3'd5, 32'hDEAD_BEE0, 32'h1234_5678, 32'hCAFE_0000, 32'h0001_0000, 3, 0);
    t_call("poke",    3'd1, 32'h0000_0200, 32'h0000_0010, 32'h0000_0100, 32'h0000_0400, 2, 1); // R7
    t_call("wrap",    3'd0, 32'h0000_0002, 32'hFFFF_FFFE, 32'h0000_0044, 32'h0000_0004, 1, 0); // R10
    t_not_call(7'h19);
    t_not_call(7'h0d);
    t_call("again",   3'd6, 32'h0BAD_F00C, 32'h0000_2000, 32'h0000_3000, 32'h0000_0008, 0, 0);
    finish_run();
  end
endmodule